// File: doc/BRIEF.md
# Far-End Alarm Codeword Receiver with Repetition Qualification

This block listens to a serial far-end alarm and control channel, one bit per cycle in which the bit-valid strobe is high. It searches the stream for 16-bit codewords. Each codeword is a run of eight ones, then a zero, then a 6-bit message, then a closing zero. The ones arrive first. The search runs at all times and depends only on the incoming bits; no control input starts or stops it.

The block counts codewords that arrive back to back and carry the same message. When the same message has been seen ten times in a row, the block copies the six bits into the top of a 16-bit status word and sets a valid flag. If the receive interrupt is enabled, the interrupt line follows that flag. A read strobe clears both the flag and the interrupt and leaves the message in place. If the channel keeps sending the same message, a new report is made after every further ten repetitions. A channel that idles with continuous ones never matches the codeword form, so it never reports.

Top module: `farend_code_rx`

## Requirements
- R1: After reset, the status word, the valid flag and the interrupt are all zero.
- R2: A codeword is accepted only when it has the following form, in arrival order: eight ones, a zero, six message bits, then a closing zero. The first message bit received lands in status bit 10 and the last lands in status bit 15.
- R3: A report (message latched, valid flag set) happens on the strobe that completes the tenth consecutive identical codeword, and not after the ninth.
- R4: A channel sending continuous ones never sets the valid flag.
- R5: A valid codeword whose message differs from the previous one restarts the repetition count at one, so the new message needs ten codewords of its own.
- R6: When 16 strobes pass after a codeword without a new valid codeword completing, the count returns to zero. A corrupted framing bit is one way this happens. The next valid codeword then counts as the first.
- R7: While the same message keeps arriving, the block reports again after every further ten repetitions.
- R8: Status word layout: bits 15..10 hold the message, bit 9 is the valid flag, and bits 8..0 read as zero.
- R9: A read strobe clears the valid flag and the interrupt on the next edge and keeps the message field. A report in the same cycle wins over the read.
- R10: The interrupt is high exactly when the valid flag is set and the interrupt enable is high. With the enable low, the valid flag is still set on a report.
- R11: Cycles with the bit-valid strobe low change neither the search state nor the repetition count, whatever the serial input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Serial bit qualifier; one channel bit per high cycle |
| bit_in | input | 1 | Serial channel data |
| irq_en | input | 1 | Receive interrupt enable |
| rd_stb | input | 1 | One-cycle read strobe of the status word |
| status_o | output | 16 | Message in [15:10], valid flag in [9], zero elsewhere |
| valid_o | output | 1 | Latched message is valid and unread |
| irq_o | output | 1 | Receive interrupt |

## Verification
The assertions assume the following about the inputs:
- The bit-valid strobe, the serial data, the read strobe and the enable are all held at defined levels from the first clock edge.
- A read strobe may arrive in any cycle, including the cycle of a report.

The stimulus keeps to these assumptions in three ways:
- Every input is driven at the falling edge, starting from time zero.
- Every channel bit is followed by a cycle with the strobe low, so gaps in the bit stream are exercised throughout.
- Before each table vector, sixteen idle ones are sent. These break the codeword lock, so no repetition count carries over from one vector to the next. Directed tests then deliberately chain codewords across message changes, corrupted frames and stalled strobes.

// File: rtl/farend_pkg.sv
// Package: shared sizing for the far-end codeword receiver.
// Assumes a codeword made of a run of ones, a zero, a message and a closing zero.
package farend_pkg;
    localparam int unsigned DEF_FLAG_W   = 8;
    localparam int unsigned DEF_MSG_W    = 6;
    localparam int unsigned DEF_REPEAT_N = 10;
    localparam int unsigned DEF_STAT_W   = 16;

    // Codeword length for a given flag and message width.
    function automatic int unsigned word_len(input int unsigned flag_w, input int unsigned msg_w);
        return flag_w + msg_w + 2;
    endfunction
endpackage

// File: rtl/farend_shifter.sv
// Module: codeword search shift register.
// Shifts one bit in at the top on each qualified strobe. It flags a match when
// the register, including the bit now arriving, holds a complete codeword.
// Assumes the first-arrived bit ends in bit 0.
module farend_shifter
    import farend_pkg::*;
#(
    parameter int unsigned FLAG_W = DEF_FLAG_W,
    parameter int unsigned MSG_W  = DEF_MSG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic             match,
    output logic [MSG_W-1:0] msg
);
    localparam int unsigned WORD_W = word_len(FLAG_W, MSG_W);
    localparam int unsigned OPEN_Z = FLAG_W;
    localparam int unsigned MSG_LO = FLAG_W + 1;
    localparam int unsigned CLOSE_Z = WORD_W - 1;

    logic [WORD_W-1:0] sreg_q;
    logic [WORD_W-1:0] sreg_nxt;
    logic [FLAG_W-1:0] flag_ok;

    // Next register value with the incoming bit placed at the top.
    always_comb sreg_nxt = {bit_in, sreg_q[WORD_W-1:1]};

    // Per-bit flag check, one term per flag position.
    for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
        assign flag_ok[g] = sreg_nxt[g];
    end

    // Codeword match on the strobe: full flag, both framing zeros.
    always_comb begin
        match = bit_en && (&flag_ok) && !sreg_nxt[OPEN_Z] && !sreg_nxt[CLOSE_Z];
        msg   = sreg_nxt[MSG_LO +: MSG_W];
    end

    // Shift register: advance only on a qualified bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      sreg_q <= '0;
        else if (bit_en) sreg_q <= sreg_nxt;
    end
endmodule

// File: rtl/farend_repeat.sv
// Module: repetition qualifier.
// Counts codewords that repeat back to back (exactly one word length apart)
// with an unchanged message. It pulses report on the completing repetition and
// re-arms. Assumes REPEAT_N >= 2.
module farend_repeat
    import farend_pkg::*;
#(
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned MSG_W    = DEF_MSG_W,
    parameter int unsigned REPEAT_N = DEF_REPEAT_N,
    parameter int unsigned CNT_W    = $clog2(REPEAT_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             match,
    input  logic [MSG_W-1:0] msg,
    output logic             report,
    output logic [CNT_W-1:0] rep_cnt
);
    localparam int unsigned GAP_W = $clog2(WORD_W);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REPEAT_N - 1);

    logic [GAP_W-1:0] since_q;
    logic             locked_q;
    logic [MSG_W-1:0] prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic             chained;

    // A match continues the run when it lands one word after the last and repeats it.
    always_comb begin
        chained = locked_q && (since_q == GAP_LAST) && (msg == prev_q);
        report  = match && chained && (cnt_q == CNT_LAST);
        rep_cnt = cnt_q;
    end

    // Bit distance since the last match; saturates when the lock is lost.
    always_ff @(posedge clk) begin
        if (!rst_n)                     since_q <= GAP_LAST;
        else if (match)                 since_q <= '0;
        else if (bit_en && since_q != GAP_LAST) since_q <= since_q + 1'b1;
    end

    // Lock flag: set by any match, dropped when a word boundary passes without one.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   locked_q <= 1'b0;
        else if (match)                               locked_q <= 1'b1;
        else if (bit_en && since_q == GAP_LAST)       locked_q <= 1'b0;
    end

    // Last accepted message, compared with the next codeword.
    always_ff @(posedge clk) begin
        if (!rst_n)     prev_q <= '0;
        else if (match) prev_q <= msg;
    end

    // Repetition count: +1 on a chained repeat, 1 on a fresh codeword, 0 on loss or report.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (match) begin
            if (!chained)    cnt_q <= CNT_W'(1);
            else if (report) cnt_q <= '0;
            else             cnt_q <= cnt_q + 1'b1;
        end else if (bit_en && since_q == GAP_LAST) begin
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/farend_status.sv
// Module: status word and interrupt.
// Latches the qualified message and a valid flag. The flag is cleared by a read
// strobe unless a report lands in the same cycle. Assumes STAT_W > MSG_W.
module farend_status
    import farend_pkg::*;
#(
    parameter int unsigned MSG_W  = DEF_MSG_W,
    parameter int unsigned STAT_W = DEF_STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              report,
    input  logic [MSG_W-1:0]  msg,
    input  logic              rd_stb,
    input  logic              irq_en,
    output logic [STAT_W-1:0] status_o,
    output logic              valid_o,
    output logic              irq_o
);
    localparam int unsigned VALID_BIT = STAT_W - MSG_W - 1;

    logic [MSG_W-1:0] msg_q;
    logic             valid_q;

    // Message holding register: loaded only on a report.
    always_ff @(posedge clk) begin
        if (!rst_n)      msg_q <= '0;
        else if (report) msg_q <= msg;
    end

    // Valid flag: report sets it with priority, read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid_q <= 1'b0;
        else if (report) valid_q <= 1'b1;
        else if (rd_stb) valid_q <= 1'b0;
    end

    // Status word assembly and interrupt gating.
    always_comb begin
        status_o = '0;
        status_o[STAT_W-1 -: MSG_W] = msg_q;
        status_o[VALID_BIT] = valid_q;
        valid_o = valid_q;
        irq_o   = valid_q && irq_en;
    end
endmodule

// File: rtl/farend_code_rx.sv
// Module: far-end alarm codeword receiver, top level.
// Chains the codeword search, the repetition qualifier and the status stage.
// Assumes one channel bit per high bit_en cycle; carrier framing is done upstream.
module farend_code_rx
    import farend_pkg::*;
#(
    parameter int unsigned FLAG_W   = DEF_FLAG_W,
    parameter int unsigned MSG_W    = DEF_MSG_W,
    parameter int unsigned REPEAT_N = DEF_REPEAT_N,
    parameter int unsigned STAT_W   = DEF_STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              irq_en,
    input  logic              rd_stb,
    output logic [STAT_W-1:0] status_o,
    output logic              valid_o,
    output logic              irq_o
);
    localparam int unsigned WORD_W = word_len(FLAG_W, MSG_W);
    localparam int unsigned CNT_W  = $clog2(REPEAT_N + 1);

    logic             match_w;
    logic [MSG_W-1:0] msg_w;
    logic             report_w;
    logic [CNT_W-1:0] rep_cnt_w;

    farend_shifter #(.FLAG_W(FLAG_W), .MSG_W(MSG_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .match(match_w), .msg(msg_w)
    );

    farend_repeat #(.WORD_W(WORD_W), .MSG_W(MSG_W), .REPEAT_N(REPEAT_N), .CNT_W(CNT_W)) u_rep (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .match(match_w), .msg(msg_w),
        .report(report_w), .rep_cnt(rep_cnt_w)
    );

    farend_status #(.MSG_W(MSG_W), .STAT_W(STAT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .report(report_w), .msg(msg_w),
        .rd_stb(rd_stb), .irq_en(irq_en),
        .status_o(status_o), .valid_o(valid_o), .irq_o(irq_o)
    );
endmodule

// File: rtl/farend_code_rx_chk.sv
// Module: property checker bound to farend_code_rx.
// Relates the port behaviour to the qualifier's internal match and report pulses.
module farend_code_rx_chk #(
    parameter int unsigned MSG_W    = 6,
    parameter int unsigned REPEAT_N = 10,
    parameter int unsigned STAT_W   = 16,
    parameter int unsigned CNT_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              irq_en,
    input logic              rd_stb,
    input logic [STAT_W-1:0] status_o,
    input logic              valid_o,
    input logic              irq_o,
    input logic              match,
    input logic [MSG_W-1:0]  msg,
    input logic              report,
    input logic [CNT_W-1:0]  rep_cnt
);
    localparam int unsigned VB = STAT_W - MSG_W - 1;

    assert_status_layout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[VB-1:0] == '0) && (status_o[VB] == valid_o));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !report |=> !valid_o);

    assert_report_latches_R3: assert property (@(posedge clk) disable iff (!rst_n)
        report |=> valid_o && (status_o[STAT_W-1 -: MSG_W] == $past(msg)));

    assert_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rep_cnt < CNT_W'(REPEAT_N));

    assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(rep_cnt) && $stable(status_o[STAT_W-1 -: MSG_W]));

    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en && valid_o);

    assert_report_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        report |-> match && bit_en);
endmodule

bind farend_code_rx farend_code_rx_chk #(
    .MSG_W(MSG_W), .REPEAT_N(REPEAT_N), .STAT_W(STAT_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .irq_en(irq_en), .rd_stb(rd_stb),
    .status_o(status_o), .valid_o(valid_o), .irq_o(irq_o),
    .match(match_w), .msg(msg_w), .report(report_w), .rep_cnt(rep_cnt_w)
);

// File: tb/test_farend_code_rx.sv
`timescale 1ns/1ps
// Bench: vector table walk, then directed tests for reset and corner cases.
module test_farend_code_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic        irq_en = 1'b0;
    logic        rd_stb = 1'b0;
    logic [15:0] status_o;
    logic        valid_o;
    logic        irq_o;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    farend_code_rx i_farend_code_rx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .irq_en(irq_en), .rd_stb(rd_stb),
        .status_o(status_o), .valid_o(valid_o), .irq_o(irq_o)
    );

    // {message, repetitions, expect valid afterwards}
    localparam logic [12:0] VEC [0:5] = '{
        {6'h2A, 6'd10, 1'b1},
        {6'h15, 6'd9,  1'b0},
        {6'h3F, 6'd10, 1'b1},
        {6'h00, 6'd10, 1'b1},
        {6'h01, 6'd11, 1'b1},
        {6'h20, 6'd20, 1'b1}
    };

    task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_in = b; bit_en = 1'b1;
        @(negedge clk); bit_en = 1'b0; bit_in = ~b;
    endtask

    task automatic send_word(input logic [5:0] m, input logic bad_close);
        logic [15:0] w;
        w = {bad_close, m, 1'b0, 8'hFF};
        for (int k = 0; k < 16; k++) send_bit(w[k]);
    endtask

    task automatic send_reps(input logic [5:0] m, input int n);
        for (int k = 0; k < n; k++) send_word(m, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) send_bit(1'b1);
    endtask

    task automatic do_read();
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(status_o == 16'h0 && !valid_o && !irq_o, "R1", status_o, 16'h0);

        irq_en = 1'b1;
        // Table walk: R2, R3, R7, R8, R9
        for (int i = 0; i < 6; i++) begin
            logic [5:0] m;
            int         n;
            logic       e;
            m = VEC[i][12:7]; n = int'(VEC[i][6:1]); e = VEC[i][0];
            idle(16);
            send_reps(m, n);
            check(valid_o == e, "R3", {15'h0, valid_o}, {15'h0, e});
            if (e) begin
                check(status_o == {m, 1'b1, 9'h0}, "R8", status_o, {m, 1'b1, 9'h0});
                check(irq_o, "R10", {15'h0, irq_o}, 16'h1);
                do_read();
                check(!valid_o && !irq_o && status_o[15:10] == m, "R9", status_o, {m, 10'h0});
            end
        end

        // R2 bit order: first message bit goes to status bit 10
        idle(16); send_reps(6'b000011, 10);
        check(status_o[15:10] == 6'b000011, "R2", status_o, {6'b000011, 1'b1, 9'h0});
        do_read();

        // R4 continuous ones never reports
        idle(400);
        check(!valid_o && !irq_o, "R4", {15'h0, valid_o}, 16'h0);

        // R5 message change restarts the count at one
        idle(16); send_reps(6'h0C, 9); send_reps(6'h31, 1);
        check(!valid_o, "R5", {15'h0, valid_o}, 16'h0);
        send_reps(6'h31, 8);
        check(!valid_o, "R5", {15'h0, valid_o}, 16'h0);
        send_reps(6'h31, 1);
        check(valid_o && status_o[15:10] == 6'h31, "R5", status_o, {6'h31, 1'b1, 9'h0});
        do_read();

        // R6 corrupted closing zero drops the count
        idle(16); send_reps(6'h12, 9); send_word(6'h12, 1'b1); send_reps(6'h12, 9);
        check(!valid_o, "R6", {15'h0, valid_o}, 16'h0);
        send_reps(6'h12, 1);
        check(valid_o && status_o[15:10] == 6'h12, "R6", status_o, {6'h12, 1'b1, 9'h0});
        do_read();

        // R7 continuous message re-arms every ten
        idle(16);
        for (int r = 0; r < 3; r++) begin
            send_reps(6'h05, 9);
            check(!valid_o, "R7", {15'h0, valid_o}, 16'h0);
            send_reps(6'h05, 1);
            check(valid_o, "R7", {15'h0, valid_o}, 16'h1);
            do_read();
        end

        // R10 enable gates the interrupt only
        irq_en = 1'b0;
        idle(16); send_reps(6'h2D, 10);
        check(valid_o && !irq_o, "R10", {14'h0, valid_o, irq_o}, 16'h2);
        @(negedge clk); irq_en = 1'b1;
        #1 check(irq_o, "R10", {15'h0, irq_o}, 16'h1);
        do_read();
        check(!irq_o && !valid_o, "R9", {14'h0, valid_o, irq_o}, 16'h0);

        // R11 stalled strobe with toggling data has no effect
        idle(16);
        for (int k = 0; k < 10; k++) begin
            logic [15:0] w;
            w = {1'b0, 6'h1B, 1'b0, 8'hFF};
            for (int b = 0; b < 16; b++) begin
                send_bit(w[b]);
                @(negedge clk); bit_in = 1'b0;
                @(negedge clk); bit_in = 1'b1;
            end
        end
        check(valid_o && status_o[15:10] == 6'h1B, "R11", status_o, {6'h1B, 1'b1, 9'h0});

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule